// File: doc/BRIEF.md
# Triggered Command Slot Sequencer

This block holds one or more sets of command slots. Each slot keeps an address, a data word and a header word. Software fills the slots through a simple register port, picks which slots take part with a per-set slot-enable mask, and marks in a per-set wait mask the slots that must finish before the next one goes out. A two-step control sequence then starts the set. First software writes the control register with the arm bit set. Then it writes the trigger bit. After that the engine walks the enabled slots from the lowest index to the highest and hands each one to a downstream request bus.

The request bus uses a valid/ready handshake. It carries the header, address and data, tagged with the set and slot index. Downstream completions come back on a separate valid-only channel that carries the same tags. Each slot records two status bits: one for issued and one for completed. When every enabled slot of a set has completed, the set returns to idle. If that set's interrupt-enable bit is set, its interrupt-status bit is also raised. Software clears the status bit by writing a one to the clear register. To reuse a set, software writes zero to its slot-enable register, which wipes the slot status bits.

Top module: `tss_top`

## Requirements
- R1: After reset, every set's idle register reads 1, `irq` is 0 and `req_valid` is 0.
- R2: The register map uses these byte addresses. Set s starts at s*672. Within a set, the wait mask is at +0x10, control at +0x14, idle at +0x18 and slot enable at +0x1C. For slot c, header is at +0x30+20c, address at +0x34+20c, data at +0x38+20c and slot status at +0x3C+20c. The header, address, data, wait and slot-enable registers read back what was written.
- R3: After a start, every slot whose enable bit is 1 is issued exactly once, in ascending slot order. Disabled slots are skipped.
- R4: When the wait bit of an issued slot is 1, no later slot of that set issues until the completion for that slot has arrived.
- R5: A slot status word has bit 8 set once the slot has been issued and bit 16 set once its completion has arrived. A slot that was never issued reads 0.
- R6: A set starts only on a control write that sets the trigger bit (24) while the trigger bit was clear and the arm bit (16) was already 1 and stays 1. Writing both bits at once from a cleared control register does not start the set.
- R7: The idle register of a set reads 0 from the start until its last enabled slot has completed, and reads 1 afterwards. `req_valid` is never high while no set is sequencing.
- R8: When a set finishes, its bit in the interrupt-status register (address 0x04, bit s) is set only if bit s of the interrupt-enable register (address 0x00) is 1. `irq` is the OR of the status bits.
- R9: Writing 1 to bit s of the clear register (address 0x08) drops status bit s.
- R10: While `req_valid` is 1 and `req_ready` is 0, the request stays valid and its tags and payload stay unchanged into the next cycle.
- R11: Writing zero to a set's slot-enable register clears the issued and completed bits of all its slots.
- R12: Each request carries the slot's stored header, address and data unchanged, tagged with its set and slot index. In an address, bits 18:16 select the target and bits 15:0 give the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by downstream |
| req_set | output | 4 | Set index of the request |
| req_slot | output | 4 | Slot index of the request |
| req_hdr | output | 32 | Header word |
| req_addr | output | 32 | Target/offset address word |
| req_data | output | 32 | Data word |
| cpl_valid | input | 1 | Completion strobe |
| cpl_set | input | 4 | Set index of the completion |
| cpl_slot | input | 4 | Slot index of the completion |
| irq | output | 1 | OR of the interrupt-status bits |

## Verification
The assertions check on every cycle that the request payload holds steady under backpressure, and that no request appears while every set is idle. They also check that a set holding on a wait bit is never granted the bus, that a start never happens without the arm bit set beforehand, and that an interrupt-status bit never rises while its enable bit is clear. Other behaviours only show in the bench's scenarios: the exact ascending issue order with skipped slots, the register readback at the computed offsets, the status-word bit positions, the effect of writing zero to the enable mask, and the refusal to start on a combined arm-and-trigger write. The scenarios also run two sets side by side under a stalling responder, with a slow completion behind a wait bit.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int REG_W       = 32;
  localparam int IDX_W       = 4;
  localparam int SET_STRIDE  = 672;
  localparam int SLOT_STRIDE = 20;

  localparam int OFS_IRQ_EN   = 'h00;
  localparam int OFS_IRQ_STS  = 'h04;
  localparam int OFS_IRQ_CLR  = 'h08;
  localparam int OFS_WAIT     = 'h10;
  localparam int OFS_CTRL     = 'h14;
  localparam int OFS_IDLE     = 'h18;
  localparam int OFS_SLOT_EN  = 'h1C;
  localparam int OFS_HDR      = 'h30;
  localparam int OFS_ADDR     = 'h34;
  localparam int OFS_DATA     = 'h38;
  localparam int OFS_SLOT_STS = 'h3C;

  localparam int CTRL_ARM_BIT   = 16;
  localparam int CTRL_FIRE_BIT  = 24;
  localparam int STS_ISSUED_BIT = 8;
  localparam int STS_DONE_BIT   = 16;

  typedef enum logic [3:0] {
    K_NONE, K_IE, K_IS, K_IC, K_WAIT, K_CTRL, K_IDLE, K_EN,
    K_HDR, K_ADDR, K_DATA, K_SSTS
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [IDX_W-1:0] set;
    logic [IDX_W-1:0] slot;
  } reg_sel_t;
endpackage

// File: rtl/tss_decode.sv
module tss_decode
  import tss_pkg::*;
#(
  parameter int NUM_SETS  = 2,
  parameter int NUM_SLOTS = 16,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel.kind = K_NONE;
    sel.set  = '0;
    sel.slot = '0;
    if (int'(addr) == OFS_IRQ_EN)  sel.kind = K_IE;
    if (int'(addr) == OFS_IRQ_STS) sel.kind = K_IS;
    if (int'(addr) == OFS_IRQ_CLR) sel.kind = K_IC;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (int'(addr) == s*SET_STRIDE + OFS_WAIT)    begin sel.kind = K_WAIT; sel.set = IDX_W'(s); end
      if (int'(addr) == s*SET_STRIDE + OFS_CTRL)    begin sel.kind = K_CTRL; sel.set = IDX_W'(s); end
      if (int'(addr) == s*SET_STRIDE + OFS_IDLE)    begin sel.kind = K_IDLE; sel.set = IDX_W'(s); end
      if (int'(addr) == s*SET_STRIDE + OFS_SLOT_EN) begin sel.kind = K_EN;   sel.set = IDX_W'(s); end
      for (int c = 0; c < NUM_SLOTS; c++) begin
        if (int'(addr) == s*SET_STRIDE + OFS_HDR + c*SLOT_STRIDE) begin
          sel.kind = K_HDR;  sel.set = IDX_W'(s); sel.slot = IDX_W'(c);
        end
        if (int'(addr) == s*SET_STRIDE + OFS_ADDR + c*SLOT_STRIDE) begin
          sel.kind = K_ADDR; sel.set = IDX_W'(s); sel.slot = IDX_W'(c);
        end
        if (int'(addr) == s*SET_STRIDE + OFS_DATA + c*SLOT_STRIDE) begin
          sel.kind = K_DATA; sel.set = IDX_W'(s); sel.slot = IDX_W'(c);
        end
        if (int'(addr) == s*SET_STRIDE + OFS_SLOT_STS + c*SLOT_STRIDE) begin
          sel.kind = K_SSTS; sel.set = IDX_W'(s); sel.slot = IDX_W'(c);
        end
      end
    end
  end
endmodule

// File: rtl/tss_set.sv
module tss_set
  import tss_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SET_ID    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_sel_t         sel,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             cpl_hit,
  input  logic [IDX_W-1:0] cpl_slot,
  input  logic             grant,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_slot,
  output logic [REG_W-1:0] req_hdr,
  output logic [REG_W-1:0] req_addr,
  output logic [REG_W-1:0] req_data,
  output logic             done,
  output logic             busy,
  output logic             armed,
  output logic             hold
);
  localparam int PTR_W = $clog2(NUM_SLOTS + 1);

  logic [REG_W-1:0] hdr_q  [NUM_SLOTS];
  logic [REG_W-1:0] addr_q [NUM_SLOTS];
  logic [REG_W-1:0] data_q [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] en_q, en_d, wait_q, wait_d, iss_q, iss_d, cmp_q, cmp_d;
  logic                 arm_q, arm_d, fire_q, fire_d;
  logic                 busy_q, busy_d, hold_q, hold_d;
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic [IDX_W-1:0]     hslot_q, hslot_d;
  logic [IDX_W-1:0]     cur;
  logic                 mine, at_end, start;

  assign mine   = wr && (sel.set == IDX_W'(SET_ID));
  assign at_end = (ptr_q == PTR_W'(NUM_SLOTS));
  assign cur    = IDX_W'(ptr_q);

  for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_slot
    logic hit;
    assign hit = mine && (sel.slot == IDX_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hdr_q[c]  <= '0;
        addr_q[c] <= '0;
        data_q[c] <= '0;
      end else begin
        if (hit && sel.kind == K_HDR)  hdr_q[c]  <= wdata;
        if (hit && sel.kind == K_ADDR) addr_q[c] <= wdata;
        if (hit && sel.kind == K_DATA) data_q[c] <= wdata;
      end
    end
  end

  assign req_valid = busy_q && !hold_q && !at_end && en_q[cur];
  assign req_slot  = cur;
  assign req_hdr   = hdr_q[cur];
  assign req_addr  = addr_q[cur];
  assign req_data  = data_q[cur];
  assign done      = busy_q && at_end && !hold_q && ((cmp_q & en_q) == en_q);
  assign busy      = busy_q;
  assign armed     = arm_q;
  assign hold      = hold_q;
  assign start     = mine && sel.kind == K_CTRL && wdata[CTRL_FIRE_BIT] &&
                     wdata[CTRL_ARM_BIT] && !fire_q && arm_q && !busy_q;

  always_comb begin
    en_d    = en_q;
    wait_d  = wait_q;
    iss_d   = iss_q;
    cmp_d   = cmp_q;
    arm_d   = arm_q;
    fire_d  = fire_q;
    busy_d  = busy_q;
    hold_d  = hold_q;
    ptr_d   = ptr_q;
    hslot_d = hslot_q;
    if (mine && sel.kind == K_EN) begin
      en_d = wdata[NUM_SLOTS-1:0];
      if (wdata == '0) begin
        iss_d = '0;
        cmp_d = '0;
      end
    end
    if (mine && sel.kind == K_WAIT) wait_d = wdata[NUM_SLOTS-1:0];
    if (mine && sel.kind == K_CTRL) begin
      arm_d  = wdata[CTRL_ARM_BIT];
      fire_d = wdata[CTRL_FIRE_BIT];
    end
    if (cpl_hit) begin
      cmp_d[cpl_slot] = 1'b1;
      if (hold_q && cpl_slot == hslot_q) hold_d = 1'b0;
    end
    if (start) begin
      busy_d = 1'b1;
      ptr_d  = '0;
      hold_d = 1'b0;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q && !hold_q && !at_end) begin
      if (!en_q[cur]) begin
        ptr_d = ptr_q + 1'b1;
      end else if (grant) begin
        iss_d[cur] = 1'b1;
        ptr_d      = ptr_q + 1'b1;
        if (wait_q[cur]) begin
          hold_d  = 1'b1;
          hslot_d = cur;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      wait_q  <= '0;
      iss_q   <= '0;
      cmp_q   <= '0;
      arm_q   <= 1'b0;
      fire_q  <= 1'b0;
      busy_q  <= 1'b0;
      hold_q  <= 1'b0;
      ptr_q   <= '0;
      hslot_q <= '0;
    end else begin
      en_q    <= en_d;
      wait_q  <= wait_d;
      iss_q   <= iss_d;
      cmp_q   <= cmp_d;
      arm_q   <= arm_d;
      fire_q  <= fire_d;
      busy_q  <= busy_d;
      hold_q  <= hold_d;
      ptr_q   <= ptr_d;
      hslot_q <= hslot_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel.set == IDX_W'(SET_ID)) begin
      case (sel.kind)
        K_WAIT: rdata = REG_W'(wait_q);
        K_EN:   rdata = REG_W'(en_q);
        K_IDLE: rdata = REG_W'(!busy_q);
        K_CTRL: begin
          rdata[CTRL_ARM_BIT]  = arm_q;
          rdata[CTRL_FIRE_BIT] = fire_q;
        end
        K_HDR:  rdata = hdr_q[sel.slot];
        K_ADDR: rdata = addr_q[sel.slot];
        K_DATA: rdata = data_q[sel.slot];
        K_SSTS: begin
          rdata[STS_ISSUED_BIT] = iss_q[sel.slot];
          rdata[STS_DONE_BIT]   = cmp_q[sel.slot];
        end
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tss_arb.sv
module tss_arb #(
  parameter int NUM_SETS = 2,
  localparam int SEL_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SETS-1:0] req,
  input  logic                ready,
  output logic                valid,
  output logic [SEL_W-1:0]    sel,
  output logic [NUM_SETS-1:0] gnt
);
  logic             lock_q, lock_d;
  logic [SEL_W-1:0] lidx_q, lidx_d, pick;
  logic             found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (req[s] && !found) begin
        pick  = SEL_W'(s);
        found = 1'b1;
      end
    end
    sel    = lock_q ? lidx_q : pick;
    valid  = |req;
    gnt    = '0;
    if (valid && ready) gnt[sel] = 1'b1;
    lock_d = valid && !ready;
    lidx_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      lidx_q <= '0;
    end else begin
      lock_q <= lock_d;
      lidx_q <= lidx_d;
    end
  end
endmodule

// File: rtl/tss_top.sv
module tss_top
  import tss_pkg::*;
#(
  parameter int NUM_SETS  = 2,
  parameter int NUM_SLOTS = 16,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [3:0]        req_set,
  output logic [3:0]        req_slot,
  output logic [31:0]       req_hdr,
  output logic [31:0]       req_addr,
  output logic [31:0]       req_data,
  input  logic              cpl_valid,
  input  logic [3:0]        cpl_set,
  input  logic [3:0]        cpl_slot,
  output logic              irq
);
  localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

  reg_sel_t             sel;
  logic [REG_W-1:0]     set_rd   [NUM_SETS];
  logic [REG_W-1:0]     set_hdr  [NUM_SETS];
  logic [REG_W-1:0]     set_addr [NUM_SETS];
  logic [REG_W-1:0]     set_data [NUM_SETS];
  logic [IDX_W-1:0]     set_slot [NUM_SETS];
  logic [NUM_SETS-1:0]  req_vec, gnt_vec, done_vec, busy_vec, arm_vec, hold_vec;
  logic [NUM_SETS-1:0]  irq_en_q, irq_en_d, irq_sts_q, irq_sts_d;
  logic [SEL_W-1:0]     arb_sel;
  logic [REG_W-1:0]     rd_sets;

  tss_decode #(.NUM_SETS(NUM_SETS), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    tss_set #(.NUM_SLOTS(NUM_SLOTS), .SET_ID(s)) u_set (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr), .wdata(bus_wdata),
      .rdata(set_rd[s]),
      .cpl_hit(cpl_valid && cpl_set == IDX_W'(s)), .cpl_slot(cpl_slot),
      .grant(gnt_vec[s]), .req_valid(req_vec[s]), .req_slot(set_slot[s]),
      .req_hdr(set_hdr[s]), .req_addr(set_addr[s]), .req_data(set_data[s]),
      .done(done_vec[s]), .busy(busy_vec[s]), .armed(arm_vec[s]), .hold(hold_vec[s])
    );
  end

  tss_arb #(.NUM_SETS(NUM_SETS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .ready(req_ready),
    .valid(req_valid), .sel(arb_sel), .gnt(gnt_vec)
  );

  assign req_set  = IDX_W'(arb_sel);
  assign req_slot = set_slot[arb_sel];
  assign req_hdr  = set_hdr[arb_sel];
  assign req_addr = set_addr[arb_sel];
  assign req_data = set_data[arb_sel];

  always_comb begin
    irq_en_d  = irq_en_q;
    irq_sts_d = irq_sts_q;
    if (bus_wr && sel.kind == K_IE) irq_en_d  = bus_wdata[NUM_SETS-1:0];
    if (bus_wr && sel.kind == K_IC) irq_sts_d = irq_sts_d & ~bus_wdata[NUM_SETS-1:0];
    irq_sts_d = irq_sts_d | (done_vec & irq_en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q  <= '0;
      irq_sts_q <= '0;
    end else begin
      irq_en_q  <= irq_en_d;
      irq_sts_q <= irq_sts_d;
    end
  end

  assign irq = |irq_sts_q;

  always_comb begin
    rd_sets = '0;
    for (int s = 0; s < NUM_SETS; s++) rd_sets = rd_sets | set_rd[s];
    case (sel.kind)
      K_IE:    bus_rdata = REG_W'(irq_en_q);
      K_IS:    bus_rdata = REG_W'(irq_sts_q);
      default: bus_rdata = rd_sets;
    endcase
  end
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int NUM_SETS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [3:0]          req_set,
  input logic [3:0]          req_slot,
  input logic [31:0]         req_hdr,
  input logic [31:0]         req_addr,
  input logic [31:0]         req_data,
  input logic [NUM_SETS-1:0] busy_vec,
  input logic [NUM_SETS-1:0] hold_vec,
  input logic [NUM_SETS-1:0] gnt_vec,
  input logic [NUM_SETS-1:0] arm_vec,
  input logic [NUM_SETS-1:0] irq_en_q,
  input logic [NUM_SETS-1:0] irq_sts_q
);
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_set) && $stable(req_slot) &&
      $stable(req_hdr) && $stable(req_addr) && $stable(req_data));

  a_r7_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy_vec != '0);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
    a_r4_no_grant_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hold_vec[s] |-> !gnt_vec[s]);

    a_r6_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_vec[s]) |-> $past(arm_vec[s]));

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_sts_q[s]) |-> $past(irq_en_q[s]));
  end
endmodule

bind tss_top tss_checker #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_set(req_set), .req_slot(req_slot), .req_hdr(req_hdr), .req_addr(req_addr),
  .req_data(req_data), .busy_vec(busy_vec), .hold_vec(hold_vec), .gnt_vec(gnt_vec),
  .arm_vec(arm_vec), .irq_en_q(irq_en_q), .irq_sts_q(irq_sts_q)
);

// File: tb/sim_tss_top.sv
module sim_tss_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [3:0]  req_set, req_slot;
  logic [31:0] req_hdr, req_addr, req_data;
  logic        cpl_valid = 1'b0;
  logic [3:0]  cpl_set = '0, cpl_slot = '0;
  logic        irq;

  always #2 clk = ~clk;

  tss_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_set(req_set), .req_slot(req_slot),
    .req_hdr(req_hdr), .req_addr(req_addr), .req_data(req_data),
    .cpl_valid(cpl_valid), .cpl_set(cpl_set), .cpl_slot(cpl_slot), .irq(irq)
  );

  typedef struct { int set; int slot; logic [31:0] hdr; logic [31:0] adr; logic [31:0] dat; } item_t;
  typedef struct { int set; int slot; int due; } pend_t;

  item_t       q0[$], q1[$];
  pend_t       pend[$];
  item_t       it;
  pend_t       pe;
  int          n_chk = 0, n_err = 0, cyc = 0, lat = 6;
  bit          stall = 1'b0;
  logic [31:0] m_hdr [2][16];
  logic [31:0] m_adr [2][16];
  logic [31:0] m_dat [2][16];
  logic [15:0] wmask [2];
  bit          cpl_seen [2][16];
  bit          last_vld [2];
  int          last_slot [2];
  bit          st_pend = 1'b0;
  logic [31:0] st_hdr, st_adr, st_dat;
  logic [3:0]  st_set, st_slot;
  logic [31:0] rv;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int a_set(input int s, input int ofs);
    return s*672 + ofs;
  endfunction
  function automatic int a_slot(input int s, input int c, input int ofs);
    return s*672 + ofs + c*20;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a);
    #1 d = bus_rdata;
  endtask

  task automatic load(input int s, input int c, input logic [31:0] h, input logic [31:0] a, input logic [31:0] d);
    m_hdr[s][c] = h; m_adr[s][c] = a; m_dat[s][c] = d;
    wr(a_slot(s, c, 'h30), h);
    wr(a_slot(s, c, 'h34), a);
    wr(a_slot(s, c, 'h38), d);
  endtask

  task automatic arm(input int s, input logic [15:0] en, input logic [15:0] wm);
    wr(a_set(s, 'h1C), 32'(en));
    wr(a_set(s, 'h10), 32'(wm));
    wmask[s] = wm;
    last_vld[s] = 1'b0;
    for (int c = 0; c < 16; c++) cpl_seen[s][c] = 1'b0;
    for (int c = 0; c < 16; c++) begin
      if (en[c]) begin
        it.set = s; it.slot = c; it.hdr = m_hdr[s][c]; it.adr = m_adr[s][c]; it.dat = m_dat[s][c];
        if (s == 0) q0.push_back(it); else q1.push_back(it);
      end
    end
    wr(a_set(s, 'h14), 32'h0001_0000);
    wr(a_set(s, 'h14), 32'h0101_0000);
  endtask

  task automatic wait_idle(input int s);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 3000 && v[0] !== 1'b1; i++) rd(a_set(s, 'h18), v);
    chk(v[0] === 1'b1, "R7 idle returns", v, 32'd1);
  endtask

  // responder, scoreboard monitor and backpressure checker
  always @(negedge clk) begin
    bit rdy;
    cyc++;
    rdy = stall ? cyc[1] : 1'b1;
    req_ready = rdy;
    if (st_pend) begin
      chk(req_valid === 1'b1 && req_set == st_set && req_slot == st_slot &&
          req_hdr == st_hdr && req_addr == st_adr && req_data == st_dat,
          "R10 request held under stall", req_addr, st_adr);
    end
    st_pend = 1'b0;
    if (req_valid === 1'b1 && !rdy) begin
      st_pend = 1'b1; st_set = req_set; st_slot = req_slot;
      st_hdr = req_hdr; st_adr = req_addr; st_dat = req_data;
    end
    if (req_valid === 1'b1 && rdy) begin
      int s;
      s = int'(req_set);
      if ((s == 0 && q0.size() == 0) || (s == 1 && q1.size() == 0) || s > 1) begin
        chk(1'b0, "R3 unexpected request", 32'(req_slot), 32'hFFFF_FFFF);
      end else begin
        it = (s == 0) ? q0.pop_front() : q1.pop_front();
        chk(int'(req_slot) == it.slot, "R3 issue order", 32'(req_slot), 32'(it.slot));
        chk(req_hdr == it.hdr && req_addr == it.adr && req_data == it.dat,
            "R12 payload", req_addr, it.adr);
        if (last_vld[s] && wmask[s][last_slot[s]])
          chk(cpl_seen[s][last_slot[s]], "R4 waited slot completed first",
              32'(req_slot), 32'(last_slot[s]));
        last_vld[s] = 1'b1;
        last_slot[s] = int'(req_slot);
        pe.set = s; pe.slot = int'(req_slot); pe.due = cyc + lat;
        pend.push_back(pe);
      end
    end
    if (pend.size() > 0 && pend[0].due <= cyc) begin
      pe = pend.pop_front();
      cpl_valid = 1'b1; cpl_set = 4'(pe.set); cpl_slot = 4'(pe.slot);
      cpl_seen[pe.set][pe.slot] = 1'b1;
    end else begin
      cpl_valid = 1'b0;
    end
  end

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 60000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 60000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(a_set(0, 'h18), rv); chk(rv == 32'd1, "R1 idle set0", rv, 32'd1);
    rd(a_set(1, 'h18), rv); chk(rv == 32'd1, "R1 idle set1", rv, 32'd1);
    chk(irq === 1'b0 && req_valid === 1'b0, "R1 irq and req low", {30'b0, irq, req_valid}, 32'd0);

    // R2 register readback
    load(1, 5, 32'h0001_0108, 32'h0003_1234, 32'hCAFE_0005);
    rd(a_slot(1, 5, 'h30), rv); chk(rv == 32'h0001_0108, "R2 header readback", rv, 32'h0001_0108);
    rd(a_slot(1, 5, 'h34), rv); chk(rv == 32'h0003_1234, "R2 address readback", rv, 32'h0003_1234);
    rd(a_slot(1, 5, 'h38), rv); chk(rv == 32'hCAFE_0005, "R2 data readback", rv, 32'hCAFE_0005);
    wr(a_set(1, 'h10), 32'h0000_8421);
    rd(a_set(1, 'h10), rv); chk(rv == 32'h0000_8421, "R2 wait mask readback", rv, 32'h0000_8421);
    wr(a_set(1, 'h1C), 32'h0000_1248);
    rd(a_set(1, 'h1C), rv); chk(rv == 32'h0000_1248, "R2 slot enable readback", rv, 32'h0000_1248);
    wr(a_set(1, 'h1C), 32'h0);

    // set 0 program
    load(0, 0, 32'h0001_0008, 32'h0002_0030, 32'h1111_0000);
    load(0, 2, 32'h0001_0108, 32'h0001_0040, 32'h2222_0002);
    load(0, 3, 32'h0001_0008, 32'h0007_FFFF, 32'h3333_0003);
    load(0, 7, 32'h0001_0108, 32'h0004_0000, 32'h7777_0007);
    wr('h00, 32'h1);

    // R6: arm and trigger together must not start
    wr(a_set(0, 'h1C), 32'h0000_008D);
    wr(a_set(0, 'h14), 32'h0101_0000);
    repeat (8) @(negedge clk);
    rd(a_set(0, 'h18), rv); chk(rv == 32'd1, "R6 no start without prior arm", rv, 32'd1);

    // proper sequence
    arm(0, 16'h008D, 16'h0004);
    rd(a_set(0, 'h18), rv); chk(rv == 32'd0, "R7 idle low while sequencing", rv, 32'd0);
    wait_idle(0);
    chk(q0.size() == 0, "R3 all enabled slots issued", 32'(q0.size()), 32'd0);
    rd(a_slot(0, 2, 'h3C), rv); chk(rv == 32'h0001_0100, "R5 issued and completed bits", rv, 32'h0001_0100);
    rd(a_slot(0, 1, 'h3C), rv); chk(rv == 32'h0, "R5 skipped slot status", rv, 32'h0);
    chk(irq === 1'b1, "R8 irq raised", {31'b0, irq}, 32'd1);
    rd('h04, rv); chk(rv == 32'h1, "R8 status bit set0", rv, 32'h1);
    wr('h08, 32'h1);
    rd('h04, rv); chk(rv == 32'h0, "R9 status cleared", rv, 32'h0);
    chk(irq === 1'b0, "R9 irq dropped", {31'b0, irq}, 32'd0);

    // R11 reuse clear
    wr(a_set(0, 'h1C), 32'h0);
    rd(a_slot(0, 2, 'h3C), rv); chk(rv == 32'h0, "R11 status wiped", rv, 32'h0);
    rd(a_slot(0, 7, 'h3C), rv); chk(rv == 32'h0, "R11 status wiped last slot", rv, 32'h0);

    // set 1 with interrupt disabled, backpressure
    stall = 1'b1; lat = 2;
    load(1, 15, 32'h0001_0008, 32'h0006_00F0, 32'hF0F0_000F);
    arm(1, 16'h8020, 16'h0000);
    wait_idle(1);
    chk(q1.size() == 0, "R3 set1 slots issued", 32'(q1.size()), 32'd0);
    rd('h04, rv); chk(rv == 32'h0, "R8 no status when disabled", rv, 32'h0);
    chk(irq === 1'b0, "R8 irq stays low", {31'b0, irq}, 32'd0);

    // both sets at once, wait on set 0 slot 1
    lat = 9;
    load(0, 1, 32'h0001_0108, 32'h0005_0010, 32'hAAAA_0001);
    load(0, 4, 32'h0001_0008, 32'h0005_0014, 32'hAAAA_0004);
    load(1, 0, 32'h0001_0008, 32'h0001_0000, 32'hBBBB_0000);
    load(1, 9, 32'h0001_0108, 32'h0001_0024, 32'hBBBB_0009);
    wr(a_set(1, 'h1C), 32'h0);
    arm(0, 16'h0012, 16'h0002);
    arm(1, 16'h0201, 16'h0000);
    wait_idle(0);
    wait_idle(1);
    chk(q0.size() == 0 && q1.size() == 0, "R3 concurrent sets drained",
        32'(q0.size() + q1.size()), 32'd0);
    rd(a_slot(1, 9, 'h3C), rv); chk(rv == 32'h0001_0100, "R5 set1 slot status", rv, 32'h0001_0100);
    rd('h04, rv); chk(rv == 32'h1, "R8 only enabled set flagged", rv, 32'h1);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule